// File: doc/BRIEF.md
# Integer-Register Conditional Float Move Sequencer

This block decides whether a floating-point register move goes ahead, based on a signed 64-bit value taken from an integer register. It also checks that the move's encoding is legal. When the move goes ahead, it issues one or two register-copy requests to the floating-point register file. The block never reads the integer register file itself; the caller presents the value together with the decoded fields. The block never moves data either; it only names source and destination register numbers and the copy width, step by step.

Each operation starts with a one-cycle `start_i` pulse while `ready_o` is high. The encoding checks come first. If any check fails, the operation finishes at once with the unimplemented flag set and no copy. If all checks pass, the 3-bit condition field is evaluated against the value. A false condition also finishes at once. A true condition produces a 32-bit copy, one 64-bit copy, or two 64-bit copies, depending on the precision field. Each copy is a request held until it is acknowledged. `done_o` pulses for one cycle when the operation ends, and the flags stay valid until the next start.

Top module: `regcond_fmove`

## Requirements
- R1: Condition code 1 moves when the value is zero; code 5 moves when it is nonzero.
- R2: Condition code 2 moves when the value is zero or negative; code 6 moves when it is strictly positive.
- R3: The value is compared as a signed two's-complement number: code 3 moves when bit 63 is set, code 7 moves when bit 63 is clear (including zero).
- R4: Condition codes 0 and 4 are reserved and end the operation with `unimpl_o`=1.
- R5: A source register number `rs1_i` greater than 15 ends the operation with `unimpl_o`=1; 15 is legal.
- R6: `imm_i`=1 ends the operation with `unimpl_o`=1.
- R7: When any encoding check fails, no copy is requested and `moved_o`=0, whatever the condition and value.
- R8: Precision 0 or 1 issues exactly one copy with `cp_wide_o`=0, source `rs2_i`, destination `rd_i`.
- R9: Precision 2 issues exactly one copy with `cp_wide_o`=1, using `rs2_i` and `rd_i` unchanged (odd numbers are not remapped).
- R10: Precision 3 issues a second 64-bit copy after the first is acknowledged, with source `rs2_i`+2 and destination `rd_i`+2 (6-bit results).
- R11: When the condition is false or the encoding is illegal, `done_o` is high in the cycle after the start edge and no request is raised.
- R12: A copy request and its register numbers and width stay stable until acknowledged; `done_o` pulses one cycle after the last acknowledge, with `moved_o`=1.
- R13: After reset, `ready_o`=1 and `cp_req_o`, `done_o`, `moved_o`, `unimpl_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken when ready_o) |
| rs1_i | input | 5 | Integer source register number (legality only) |
| imm_i | input | 1 | Immediate bit of the encoding |
| cond_i | input | 3 | Register condition field |
| prec_i | input | 2 | Precision field |
| rs2_i | input | 5 | Float source register number |
| rd_i | input | 5 | Float destination register number |
| val_i | input | 64 | Integer register value |
| cp_ack_i | input | 1 | Copy step acknowledge |
| ready_o | output | 1 | Idle, can accept start |
| cp_req_o | output | 1 | Copy step request |
| cp_wide_o | output | 1 | 1 = 64-bit copy, 0 = 32-bit copy |
| cp_src_o | output | 6 | Copy source register number |
| cp_dst_o | output | 6 | Copy destination register number |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| moved_o | output | 1 | Move was performed |
| unimpl_o | output | 1 | Encoding was rejected |

## Verification
The bench probes the boundaries of the signed comparison: zero under the less-or-equal and greater-or-equal codes, the most negative value, and -1. A design that compared unsigned, or that treated zero as positive, would move on the wrong side of those values. Reserved codes, rs1 of 16 against 15, and a set immediate bit are each sent with a condition that would otherwise be true. A design that evaluated the condition before the legality checks would raise a copy request there. For the quad case it drives rs2=30 and odd register numbers, and it delays the acknowledge. This exposes any remapping of odd numbers, a wrap of the +2 offset into 5 bits, or a request that drops or changes before it is acknowledged.

// File: rtl/regcond_fmove_pkg.sv
package regcond_fmove_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_COPY = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_t;

   // condition codes of the 3-bit field
   localparam logic [2:0] CC_RSV0 = 3'd0;
   localparam logic [2:0] CC_EQZ  = 3'd1;
   localparam logic [2:0] CC_LEZ  = 3'd2;
   localparam logic [2:0] CC_LTZ  = 3'd3;
   localparam logic [2:0] CC_RSV4 = 3'd4;
   localparam logic [2:0] CC_NEZ  = 3'd5;
   localparam logic [2:0] CC_GTZ  = 3'd6;
   localparam logic [2:0] CC_GEZ  = 3'd7;
endpackage

// File: rtl/regcond_eval.sv
module regcond_eval
   import regcond_fmove_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int REG_W      = 5,
   parameter int GLOBAL_MAX = 15
) (
   input  logic [REG_W-1:0]  rs1_i,
   input  logic              imm_i,
   input  logic [2:0]        cond_i,
   input  logic [DATA_W-1:0] val_i,
   output logic              illegal_o,
   output logic              take_o
);
   logic is_zero;
   logic is_neg;
   logic cond_bad;

   assign is_zero = ~|val_i;
   assign is_neg  = val_i[DATA_W-1];

   always_comb begin
      cond_bad = 1'b0;
      take_o   = 1'b0;
      unique case (cond_i)
         CC_EQZ:  take_o = is_zero;
         CC_LEZ:  take_o = is_zero | is_neg;
         CC_LTZ:  take_o = is_neg;
         CC_NEZ:  take_o = ~is_zero;
         CC_GTZ:  take_o = ~is_zero & ~is_neg;
         CC_GEZ:  take_o = ~is_neg;
         default: cond_bad = 1'b1;
      endcase
   end

   assign illegal_o = cond_bad | imm_i | (32'(rs1_i) > GLOBAL_MAX);
endmodule

// File: rtl/regcond_step_addr.sv
module regcond_step_addr #(
   parameter int REG_W     = 5,
   parameter int MAX_STEPS = 2,
   parameter int STRIDE    = 2,
   localparam int STEP_W   = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1
) (
   input  logic [REG_W-1:0]  rs2_i,
   input  logic [REG_W-1:0]  rd_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [REG_W:0]    src_o,
   output logic [REG_W:0]    dst_o
);
   logic [REG_W:0] src_tab [MAX_STEPS];
   logic [REG_W:0] dst_tab [MAX_STEPS];

   for (genvar s = 0; s < MAX_STEPS; s++) begin : g_step
      localparam logic [REG_W:0] OFS = (REG_W+1)'(s * STRIDE);
      assign src_tab[s] = {1'b0, rs2_i} + OFS;
      assign dst_tab[s] = {1'b0, rd_i} + OFS;
   end

   assign src_o = src_tab[step_i];
   assign dst_o = dst_tab[step_i];
endmodule

// File: rtl/regcond_fmove.sv
module regcond_fmove
   import regcond_fmove_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int REG_W      = 5,
   parameter int PREC_W     = 2,
   parameter int GLOBAL_MAX = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [REG_W-1:0]  rs1_i,
   input  logic              imm_i,
   input  logic [2:0]        cond_i,
   input  logic [PREC_W-1:0] prec_i,
   input  logic [REG_W-1:0]  rs2_i,
   input  logic [REG_W-1:0]  rd_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic              cp_ack_i,
   output logic              ready_o,
   output logic              cp_req_o,
   output logic              cp_wide_o,
   output logic [REG_W:0]    cp_src_o,
   output logic [REG_W:0]    cp_dst_o,
   output logic              done_o,
   output logic              moved_o,
   output logic              unimpl_o
);
   localparam int MAX_STEPS = 2;
   localparam int STEP_W    = 1;
   localparam logic [PREC_W-1:0] PREC_WIDE = PREC_W'(2);

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (PREC_W < 2) begin : g_bad_prec
      $error("PREC_W must be at least 2");
   end
   if (GLOBAL_MAX >= (1 << REG_W)) begin : g_bad_glob
      $error("GLOBAL_MAX must fit in REG_W bits");
   end

   seq_state_t        state_q;
   logic [REG_W-1:0]  rs2_q, rd_q;
   logic              wide_q, two_q;
   logic [STEP_W-1:0] step_q;
   logic              moved_q, unimpl_q;
   logic              illegal, take;
   logic              accept;

   regcond_eval #(
      .DATA_W(DATA_W), .REG_W(REG_W), .GLOBAL_MAX(GLOBAL_MAX)
   ) u_eval (
      .rs1_i(rs1_i), .imm_i(imm_i), .cond_i(cond_i), .val_i(val_i),
      .illegal_o(illegal), .take_o(take)
   );

   regcond_step_addr #(
      .REG_W(REG_W), .MAX_STEPS(MAX_STEPS), .STRIDE(2)
   ) u_addr (
      .rs2_i(rs2_q), .rd_i(rd_q), .step_i(step_q),
      .src_o(cp_src_o), .dst_o(cp_dst_o)
   );

   assign accept = start_i && (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         rs2_q    <= '0;
         rd_q     <= '0;
         wide_q   <= 1'b0;
         two_q    <= 1'b0;
         step_q   <= '0;
         moved_q  <= 1'b0;
         unimpl_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               rs2_q    <= rs2_i;
               rd_q     <= rd_i;
               wide_q   <= prec_i >= PREC_WIDE;
               two_q    <= prec_i > PREC_WIDE;
               step_q   <= '0;
               unimpl_q <= illegal;
               moved_q  <= take & ~illegal;
               state_q  <= (take & ~illegal) ? ST_COPY : ST_FIN;
            end
            ST_COPY: if (cp_ack_i) begin
               if (two_q && step_q == '0) step_q <= step_q + 1'b1;
               else                       state_q <= ST_FIN;
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ready_o   = (state_q == ST_IDLE);
   assign cp_req_o  = (state_q == ST_COPY);
   assign cp_wide_o = wide_q;
   assign done_o    = (state_q == ST_FIN);
   assign moved_o   = moved_q;
   assign unimpl_o  = unimpl_q;
endmodule

// File: rtl/regcond_fmove_chk.sv
module regcond_fmove_chk #(
   parameter int REG_W      = 5,
   parameter int GLOBAL_MAX = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [REG_W-1:0] rs1_i,
   input logic             imm_i,
   input logic             cp_ack_i,
   input logic             ready_o,
   input logic             cp_req_o,
   input logic             cp_wide_o,
   input logic [REG_W:0]   cp_src_o,
   input logic [REG_W:0]   cp_dst_o,
   input logic             done_o,
   input logic             moved_o,
   input logic             unimpl_o
);
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cp_req_o && !cp_ack_i |=> cp_req_o && $stable(cp_src_o)
                               && $stable(cp_dst_o) && $stable(cp_wide_o));

   a_r7_unimpl_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && unimpl_o |-> !moved_o);

   a_r6_imm_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && ready_o && imm_i |=> done_o && unimpl_o && !cp_req_o);

   a_r5_rs1_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && ready_o && (32'(rs1_i) > GLOBAL_MAX) |=> done_o && unimpl_o);

   a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> !cp_req_o && !done_o);

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && ready_o);
endmodule

bind regcond_fmove regcond_fmove_chk #(
   .REG_W(REG_W), .GLOBAL_MAX(GLOBAL_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .rs1_i(rs1_i), .imm_i(imm_i),
   .cp_ack_i(cp_ack_i), .ready_o(ready_o), .cp_req_o(cp_req_o),
   .cp_wide_o(cp_wide_o), .cp_src_o(cp_src_o), .cp_dst_o(cp_dst_o),
   .done_o(done_o), .moved_o(moved_o), .unimpl_o(unimpl_o)
);

// File: tb/regcond_fmove_tb_top.sv
module regcond_fmove_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [4:0]  rs1_i = '0;
   logic        imm_i = 1'b0;
   logic [2:0]  cond_i = '0;
   logic [1:0]  prec_i = '0;
   logic [4:0]  rs2_i = '0;
   logic [4:0]  rd_i = '0;
   logic [63:0] val_i = '0;
   logic        cp_ack_i = 1'b0;
   logic        ready_o, cp_req_o, cp_wide_o, done_o, moved_o, unimpl_o;
   logic [5:0]  cp_src_o, cp_dst_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   regcond_fmove dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rs1_i(rs1_i),
      .imm_i(imm_i), .cond_i(cond_i), .prec_i(prec_i), .rs2_i(rs2_i),
      .rd_i(rd_i), .val_i(val_i), .cp_ack_i(cp_ack_i), .ready_o(ready_o),
      .cp_req_o(cp_req_o), .cp_wide_o(cp_wide_o), .cp_src_o(cp_src_o),
      .cp_dst_o(cp_dst_o), .done_o(done_o), .moved_o(moved_o),
      .unimpl_o(unimpl_o)
   );

   // results of the last operation
   int         n_cp, lat;
   logic [5:0] src_r [2];
   logic [5:0] dst_r [2];
   logic       wide_r [2];
   logic       un_r, mv_r, stable_ok, ended;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit exp_take(input logic [2:0] c, input logic [63:0] v);
      longint sv = $signed(v);
      case (c)
         3'd1: return sv == 0;
         3'd2: return sv <= 0;
         3'd3: return sv < 0;
         3'd5: return sv != 0;
         3'd6: return sv > 0;
         3'd7: return sv >= 0;
         default: return 1'b0;
      endcase
   endfunction

   task automatic run_op(input logic [4:0] r1, input logic im, input logic [2:0] c,
                         input logic [1:0] p, input logic [4:0] s2, input logic [4:0] d,
                         input logic [63:0] v, input int ack_delay);
      @(negedge clk);
      rs1_i = r1; imm_i = im; cond_i = c; prec_i = p; rs2_i = s2; rd_i = d; val_i = v;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n_cp = 0; lat = 0; stable_ok = 1'b1; ended = 1'b0; un_r = 1'b0; mv_r = 1'b0;
      for (int i = 0; i < 60; i++) begin
         if (done_o) begin
            un_r = unimpl_o; mv_r = moved_o; ended = 1'b1;
            break;
         end
         if (cp_req_o) begin
            if (n_cp < 2) begin
               src_r[n_cp] = cp_src_o; dst_r[n_cp] = cp_dst_o; wide_r[n_cp] = cp_wide_o;
            end
            for (int k = 0; k < ack_delay; k++) begin
               @(negedge clk);
               lat++;
               if (!cp_req_o || cp_src_o != src_r[n_cp & 1] || cp_dst_o != dst_r[n_cp & 1])
                  stable_ok = 1'b0;
            end
            cp_ack_i = 1'b1;
            @(negedge clk);
            cp_ack_i = 1'b0;
            n_cp++;
         end else begin
            @(negedge clk);
         end
         lat++;
      end
      chk(ended, "done reached", ended, 1);
   endtask

   task automatic cond_case(input string req, input logic [2:0] c, input logic [63:0] v);
      bit t = exp_take(c, v);
      run_op(5'd3, 1'b0, c, 2'd0, 5'd4, 5'd8, v, 0);
      chk(mv_r == t, req, mv_r, t);
      chk(n_cp == int'(t), req, n_cp, t);
      chk(un_r == 1'b0, req, un_r, 0);
      if (!t) chk(lat == 0, {req, "/R11 latency"}, lat, 0);
   endtask

   task automatic t_reset();
      chk(ready_o == 1'b1, "R13 ready", ready_o, 1);
      chk(cp_req_o == 1'b0, "R13 req", cp_req_o, 0);
      chk(done_o == 1'b0, "R13 done", done_o, 0);
      chk(moved_o == 1'b0, "R13 moved", moved_o, 0);
      chk(unimpl_o == 1'b0, "R13 unimpl", unimpl_o, 0);
   endtask

   task automatic t_r1();
      cond_case("R1", 3'd1, 64'd0);
      cond_case("R1", 3'd1, 64'd5);
      cond_case("R1", 3'd5, 64'd0);
      cond_case("R1", 3'd5, '1);
   endtask

   task automatic t_r2();
      cond_case("R2", 3'd2, 64'd0);
      cond_case("R2", 3'd2, -64'sd3);
      cond_case("R2", 3'd2, 64'd7);
      cond_case("R2", 3'd6, 64'd7);
      cond_case("R2", 3'd6, 64'd0);
      cond_case("R2", 3'd6, 64'h8000_0000_0000_0000);
   endtask

   task automatic t_r3();
      cond_case("R3", 3'd3, 64'h8000_0000_0000_0000);
      cond_case("R3", 3'd3, 64'd1);
      cond_case("R3", 3'd3, 64'd0);
      cond_case("R3", 3'd7, 64'd0);
      cond_case("R3", 3'd7, '1);
      cond_case("R3", 3'd7, 64'h7FFF_FFFF_FFFF_FFFF);
   endtask

   task automatic reject_case(input string req, input logic [4:0] r1, input logic im,
                              input logic [2:0] c);
      run_op(r1, im, c, 2'd3, 5'd2, 5'd6, 64'd0, 0);
      chk(un_r == 1'b1, req, un_r, 1);
      chk(n_cp == 0, {req, "/R7 copies"}, n_cp, 0);
      chk(mv_r == 1'b0, {req, "/R7 moved"}, mv_r, 0);
      chk(lat == 0, {req, "/R11 latency"}, lat, 0);
   endtask

   task automatic t_r4();
      reject_case("R4", 5'd1, 1'b0, 3'd0);
      reject_case("R4", 5'd1, 1'b0, 3'd4);
   endtask

   task automatic t_r5();
      reject_case("R5", 5'd16, 1'b0, 3'd7);
      reject_case("R5", 5'd31, 1'b0, 3'd1);
      run_op(5'd15, 1'b0, 3'd7, 2'd0, 5'd1, 5'd2, 64'd0, 0);
      chk(un_r == 1'b0, "R5 rs1=15 legal", un_r, 0);
      chk(mv_r == 1'b1, "R5 rs1=15 moved", mv_r, 1);
   endtask

   task automatic t_r6();
      reject_case("R6", 5'd0, 1'b1, 3'd7);
   endtask

   task automatic t_r8();
      for (int p = 0; p < 2; p++) begin
         run_op(5'd2, 1'b0, 3'd1, 2'(p), 5'd7, 5'd9, 64'd0, 0);
         chk(n_cp == 1, "R8 count", n_cp, 1);
         chk(wide_r[0] == 1'b0, "R8 width", wide_r[0], 0);
         chk(src_r[0] == 6'd7, "R8 src", src_r[0], 7);
         chk(dst_r[0] == 6'd9, "R8 dst", dst_r[0], 9);
      end
   endtask

   task automatic t_r9();
      run_op(5'd2, 1'b0, 3'd1, 2'd2, 5'd3, 5'd5, 64'd0, 0);
      chk(n_cp == 1, "R9 count", n_cp, 1);
      chk(wide_r[0] == 1'b1, "R9 width", wide_r[0], 1);
      chk(src_r[0] == 6'd3, "R9 src", src_r[0], 3);
      chk(dst_r[0] == 6'd5, "R9 dst", dst_r[0], 5);
   endtask

   task automatic t_r10();
      run_op(5'd2, 1'b0, 3'd7, 2'd3, 5'd30, 5'd4, 64'd9, 0);
      chk(n_cp == 2, "R10 count", n_cp, 2);
      chk(src_r[0] == 6'd30, "R10 src0", src_r[0], 30);
      chk(dst_r[0] == 6'd4, "R10 dst0", dst_r[0], 4);
      chk(src_r[1] == 6'd32, "R10 src1", src_r[1], 32);
      chk(dst_r[1] == 6'd6, "R10 dst1", dst_r[1], 6);
      chk(wide_r[0] && wide_r[1], "R10 width", wide_r[1], 1);
      chk(mv_r == 1'b1, "R10 moved", mv_r, 1);
   endtask

   task automatic t_r12();
      run_op(5'd2, 1'b0, 3'd5, 2'd3, 5'd11, 5'd29, 64'd1, 3);
      chk(stable_ok == 1'b1, "R12 held until ack", stable_ok, 1);
      chk(n_cp == 2, "R12 count", n_cp, 2);
      chk(lat == 8, "R12 done after last ack", lat, 8);
      chk(mv_r == 1'b1, "R12 moved", mv_r, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_r1();
      t_r2();
      t_r3();
      t_r4();
      t_r5();
      t_r6();
      t_r8();
      t_r9();
      t_r10();
      t_r12();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule